// File: doc/BRIEF.md
# Store Queue with Read Overtaking

This block sits between a write-through cache and a slower memory. Every processor store (and every dirty line a write-back cache evicts) is pushed into a small queue, and the memory side retires those writes one at a time in the order they arrived. A read miss does not wait for the queue to empty. It is sent to memory ahead of all queued writes. Before it goes, its word address is compared against every occupied slot, so the answer still reflects the newest stored bytes.

A single read machine owns the memory port. In `RS_IDLE` it accepts a read request. If there is none, it offers the oldest queued write. On acceptance it takes a snapshot of the bytes forwarded from the queue. It then moves to `RS_RESP` when those bytes cover the whole word, and to `RS_ISSUE` otherwise. `RS_ISSUE` holds the memory read until it is accepted and then moves to `RS_WAIT`. `RS_WAIT` merges the returned word with the snapshot when read data arrives and moves to `RS_RESP`. `RS_RESP` presents the answer for one cycle and returns to `RS_IDLE`.

An evicted dirty line is pushed through the same store port. Its refill read then overtakes it in the way described above.

Top module: `wbuf_bypass_top`

## Requirements
- R1: During and right after reset, st_ready and rd_req_ready are 1, and mem_valid and rd_resp_valid are 0.
- R2: The queue holds 4 entries. With 4 entries stored, st_ready is 0 and stays 0 until a write is retired to memory.
- R3: A store accepted in the same cycle as a write retired to memory leaves the occupancy unchanged.
- R4: Queued writes reach memory (mem_valid=1, mem_we=1) oldest first, each with its own address, data and byte enables. Byte lane i is data bits 8i+7:8i, enabled by be bit i.
- R5: A read accepted in `RS_IDLE` is sent to memory before any queued write. A write offered in a cycle with a pending read request is withdrawn (the memory port only transfers when mem_valid and mem_ready are both 1).
- R6: A read whose address matches no queued entry is issued to memory (mem_valid=1, mem_we=0) in the cycle after acceptance and holds its address until accepted. Its response equals the memory word unchanged.
- R7: A read whose address matches queued entries returns each byte from the youngest matching entry whose enable for that lane is set. Bytes with no such entry come from memory.
- R8: When the matching entries together enable all 4 byte lanes, no memory read is made and rd_resp_valid rises in the cycle after acceptance.
- R9: Only one read is in flight. rd_req_ready is 0 from the cycle after acceptance until the response, and rd_resp_valid is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store (or evicted line) offered |
| st_ready | output | 1 | Queue can take a store |
| st_addr | input | AW | Store word address |
| st_data | input | DW | Store data |
| st_be | input | DW/8 | Store byte enables |
| rd_req_valid | input | 1 | Read miss request |
| rd_req_ready | output | 1 | Read request accepted |
| rd_req_addr | input | AW | Read word address |
| rd_resp_valid | output | 1 | Read answer pulse |
| rd_resp_data | output | DW | Read answer data |
| mem_valid | output | 1 | Memory request offered |
| mem_ready | input | 1 | Memory takes the request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Write data |
| mem_be | output | DW/8 | Write byte enables |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | DW | Returned word |

## Verification
Reads are issued against a memory whose write acceptance the bench can shut. Queued writes therefore stay queued while reads run past them. A read to an address with no queued write separates true bypass from a wrongly merged answer. Three overlapping partial stores to one word separate correct youngest-wins byte merging from oldest-wins or whole-word forwarding. A fully covered word shows whether the memory read is skipped, which the bench sees in its count of memory reads. Repeating the reads after the queue drains, plus a store accepted in the same cycle as a retirement, exposes retirement order, byte-enable handling and occupancy errors through the memory contents and st_ready.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
    typedef enum logic [1:0] {
        RS_IDLE  = 2'd0,
        RS_ISSUE = 2'd1,
        RS_WAIT  = 2'd2,
        RS_RESP  = 2'd3
    } rd_state_e;
endpackage

// File: rtl/wbuf_fifo.sv
module wbuf_fifo #(
    parameter int AW    = 8,
    parameter int DW    = 32,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [AW-1:0]    push_addr_i,
    input  logic [DW-1:0]    push_data_i,
    input  logic [DW/8-1:0]  push_be_i,
    input  logic             pop_i,
    output logic [AW-1:0]    head_addr_o,
    output logic [DW-1:0]    head_data_o,
    output logic [DW/8-1:0]  head_be_o,
    output logic             empty_o,
    output logic             full_o,
    input  logic [AW-1:0]    look_addr_i,
    output logic [DW-1:0]    fwd_data_o,
    output logic [DW/8-1:0]  fwd_be_o
);
    localparam int BW = DW / 8;
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [AW-1:0]   addr_q [DEPTH];
    logic [DW-1:0]   data_q [DEPTH];
    logic [BW-1:0]   be_q   [DEPTH];
    logic [DEPTH-1:0] vld_q;
    logic [DEPTH-1:0] hit;
    logic [PW-1:0]   rd_ptr, wr_ptr;
    logic [CW-1:0]   cnt;

    assign empty_o     = (cnt == '0);
    assign full_o      = (cnt == CW'(DEPTH));
    assign head_addr_o = addr_q[rd_ptr];
    assign head_data_o = data_q[rd_ptr];
    assign head_be_o   = be_q[rd_ptr];

    // one comparator per slot
    for (genvar e = 0; e < DEPTH; e++) begin : g_cmp
        assign hit[e] = vld_q[e] && (addr_q[e] == look_addr_i);
    end

    // walk slots oldest to youngest; later slots overwrite earlier bytes
    always_comb begin
        fwd_data_o = '0;
        fwd_be_o   = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (hit[rd_ptr + PW'(k)]) begin
                for (int b = 0; b < BW; b++) begin
                    if (be_q[rd_ptr + PW'(k)][b]) begin
                        fwd_be_o[b]          = 1'b1;
                        fwd_data_o[8*b +: 8] = data_q[rd_ptr + PW'(k)][8*b +: 8];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (push_i) begin
            addr_q[wr_ptr] <= push_addr_i;
            data_q[wr_ptr] <= push_data_i;
            be_q[wr_ptr]   <= push_be_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
            vld_q  <= '0;
        end else begin
            if (push_i) begin
                vld_q[wr_ptr] <= 1'b1;
                wr_ptr        <= wr_ptr + PW'(1);
            end
            if (pop_i) begin
                vld_q[rd_ptr] <= 1'b0;
                rd_ptr        <= rd_ptr + PW'(1);
            end
            unique case ({push_i, pop_i})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    AST_PUSH_POP_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i) |=> $stable(cnt)); // R3
    AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> (vld_q[rd_ptr] && !empty_o)); // R4
endmodule

// File: rtl/wbuf_rd_ctrl.sv
module wbuf_rd_ctrl
    import wbuf_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_req_valid_i,
    input  logic [AW-1:0]    rd_req_addr_i,
    output logic             rd_req_ready_o,
    output logic             rd_resp_valid_o,
    output logic [DW-1:0]    rd_resp_data_o,
    input  logic [DW-1:0]    fwd_data_i,
    input  logic [DW/8-1:0]  fwd_be_i,
    input  logic             empty_i,
    input  logic [AW-1:0]    head_addr_i,
    input  logic [DW-1:0]    head_data_i,
    input  logic [DW/8-1:0]  head_be_i,
    output logic             pop_o,
    output logic             mem_valid_o,
    input  logic             mem_ready_i,
    output logic             mem_we_o,
    output logic [AW-1:0]    mem_addr_o,
    output logic [DW-1:0]    mem_wdata_o,
    output logic [DW/8-1:0]  mem_be_o,
    input  logic             mem_rvalid_i,
    input  logic [DW-1:0]    mem_rdata_i
);
    localparam int BW = DW / 8;

    rd_state_e     state, nxt;
    logic [AW-1:0] rd_addr_q;
    logic [DW-1:0] fwd_data_q, resp_q, merged;
    logic [BW-1:0] fwd_be_q;
    logic          accept;

    assign accept         = (state == RS_IDLE) && rd_req_valid_i;
    assign rd_resp_data_o = resp_q;

    always_comb begin
        for (int b = 0; b < BW; b++) begin
            merged[8*b +: 8] = fwd_be_q[b] ? fwd_data_q[8*b +: 8] : mem_rdata_i[8*b +: 8];
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            RS_IDLE:  if (rd_req_valid_i) nxt = (&fwd_be_i) ? RS_RESP : RS_ISSUE;
            RS_ISSUE: if (mem_ready_i)    nxt = RS_WAIT;
            RS_WAIT:  if (mem_rvalid_i)   nxt = RS_RESP;
            RS_RESP:                      nxt = RS_IDLE;
            default:                      nxt = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= RS_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_addr_q  <= '0;
            fwd_data_q <= '0;
            fwd_be_q   <= '0;
            resp_q     <= '0;
        end else if (accept) begin
            rd_addr_q  <= rd_req_addr_i;
            fwd_data_q <= fwd_data_i;
            fwd_be_q   <= fwd_be_i;
            resp_q     <= fwd_data_i;
        end else if ((state == RS_WAIT) && mem_rvalid_i) begin
            resp_q <= merged;
        end
    end

    always_comb begin
        rd_req_ready_o  = 1'b0;
        rd_resp_valid_o = 1'b0;
        pop_o           = 1'b0;
        mem_valid_o     = 1'b0;
        mem_we_o        = 1'b0;
        mem_addr_o      = head_addr_i;
        mem_wdata_o     = head_data_i;
        mem_be_o        = head_be_i;
        unique case (state)
            RS_IDLE: begin
                rd_req_ready_o = 1'b1;
                if (!rd_req_valid_i && !empty_i) begin
                    mem_valid_o = 1'b1;
                    mem_we_o    = 1'b1;
                    pop_o       = mem_ready_i;
                end
            end
            RS_ISSUE: begin
                mem_valid_o = 1'b1;
                mem_addr_o  = rd_addr_q;
                mem_wdata_o = '0;
                mem_be_o    = '1;
            end
            RS_WAIT: ;
            RS_RESP: rd_resp_valid_o = 1'b1;
            default: ;
        endcase
    end

    AST_READ_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_valid_i && rd_req_ready_o) |-> !(mem_valid_o && mem_we_o)); // R5
    AST_MISS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_valid_i && rd_req_ready_o && !(&fwd_be_i)) |=> (mem_valid_o && !mem_we_o)); // R6
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid_o && !mem_we_o && !mem_ready_i) |=> (mem_valid_o && !mem_we_o && $stable(mem_addr_o))); // R6
    AST_COVER_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_valid_i && rd_req_ready_o && (&fwd_be_i)) |=> (rd_resp_valid_o && !mem_valid_o)); // R8
    AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_resp_valid_o |=> !rd_resp_valid_o); // R9
    AST_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_valid_i && rd_req_ready_o) |=> !rd_req_ready_o); // R9
endmodule

// File: rtl/wbuf_bypass_top.sv
module wbuf_bypass_top #(
    parameter int AW    = 8,
    parameter int DW    = 32,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             st_valid,
    output logic             st_ready,
    input  logic [AW-1:0]    st_addr,
    input  logic [DW-1:0]    st_data,
    input  logic [DW/8-1:0]  st_be,
    input  logic             rd_req_valid,
    output logic             rd_req_ready,
    input  logic [AW-1:0]    rd_req_addr,
    output logic             rd_resp_valid,
    output logic [DW-1:0]    rd_resp_data,
    output logic             mem_valid,
    input  logic             mem_ready,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    output logic [DW/8-1:0]  mem_be,
    input  logic             mem_rvalid,
    input  logic [DW-1:0]    mem_rdata
);
    localparam int BW = DW / 8;

    logic          push, pop, empty, full;
    logic [AW-1:0] head_addr;
    logic [DW-1:0] head_data, fwd_data;
    logic [BW-1:0] head_be, fwd_be;

    assign st_ready = !full;
    assign push     = st_valid && !full;

    wbuf_fifo #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) i_fifo (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push),
        .push_addr_i (st_addr),
        .push_data_i (st_data),
        .push_be_i   (st_be),
        .pop_i       (pop),
        .head_addr_o (head_addr),
        .head_data_o (head_data),
        .head_be_o   (head_be),
        .empty_o     (empty),
        .full_o      (full),
        .look_addr_i (rd_req_addr),
        .fwd_data_o  (fwd_data),
        .fwd_be_o    (fwd_be)
    );

    wbuf_rd_ctrl #(.AW(AW), .DW(DW)) i_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .rd_req_valid_i  (rd_req_valid),
        .rd_req_addr_i   (rd_req_addr),
        .rd_req_ready_o  (rd_req_ready),
        .rd_resp_valid_o (rd_resp_valid),
        .rd_resp_data_o  (rd_resp_data),
        .fwd_data_i      (fwd_data),
        .fwd_be_i        (fwd_be),
        .empty_i         (empty),
        .head_addr_i     (head_addr),
        .head_data_i     (head_data),
        .head_be_i       (head_be),
        .pop_o           (pop),
        .mem_valid_o     (mem_valid),
        .mem_ready_i     (mem_ready),
        .mem_we_o        (mem_we),
        .mem_addr_o      (mem_addr),
        .mem_wdata_o     (mem_wdata),
        .mem_be_o        (mem_be),
        .mem_rvalid_i    (mem_rvalid),
        .mem_rdata_i     (mem_rdata)
    );

    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_ready && !(mem_valid && mem_we && mem_ready)) |=> !st_ready); // R2
    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (st_ready && rd_req_ready && !mem_valid && !rd_resp_valid)); // R1
endmodule

// File: tb/test_wbuf_bypass_top.sv
`timescale 1ns/1ps
module test_wbuf_bypass_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st_valid = 1'b0, rd_req_valid = 1'b0;
    logic [7:0]  st_addr = '0, rd_req_addr = '0;
    logic [31:0] st_data = '0;
    logic [3:0]  st_be = '0;
    logic        st_ready, rd_req_ready, rd_resp_valid;
    logic [31:0] rd_resp_data;
    logic        mem_valid, mem_ready, mem_we, mem_rvalid;
    logic [7:0]  mem_addr;
    logic [31:0] mem_wdata, mem_rdata;
    logic [3:0]  mem_be;

    int total = 0, bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    wbuf_bypass_top i_wbuf_bypass_top (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr),
        .st_data(st_data), .st_be(st_be),
        .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
        .rd_req_addr(rd_req_addr),
        .rd_resp_valid(rd_resp_valid), .rd_resp_data(rd_resp_data),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    // memory model: writes gated by wr_open, reads answered after rlat cycles
    logic [31:0] bmem [16];
    logic        wr_open = 1'b0;
    logic        rd_pend;
    int          rd_cnt;
    logic [3:0]  rd_a;
    int          nrd, nwr, ntx;
    logic [7:0]  wlog [32];
    logic        first_we;
    logic [7:0]  first_addr;
    localparam int RLAT = 3;

    assign mem_ready = mem_we ? wr_open : 1'b1;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) bmem[i] <= {8{i[3:0]}};
            rd_pend <= 1'b0; rd_cnt <= 0; rd_a <= '0;
            nrd <= 0; nwr <= 0; ntx <= 0;
            mem_rvalid <= 1'b0; mem_rdata <= '0;
            first_we <= 1'b1; first_addr <= '0;
        end else begin
            mem_rvalid <= 1'b0;
            if (mem_valid && mem_ready) begin
                ntx <= ntx + 1;
                if (ntx == 0) begin first_we <= mem_we; first_addr <= mem_addr; end
                if (mem_we) begin
                    for (int b = 0; b < 4; b++)
                        if (mem_be[b]) bmem[mem_addr[3:0]][8*b +: 8] <= mem_wdata[8*b +: 8];
                    if (nwr < 32) wlog[nwr] <= mem_addr;
                    nwr <= nwr + 1;
                end else begin
                    nrd <= nrd + 1;
                    rd_pend <= 1'b1; rd_cnt <= RLAT; rd_a <= mem_addr[3:0];
                end
            end
            if (rd_pend) begin
                if (rd_cnt == 0) begin
                    mem_rvalid <= 1'b1; mem_rdata <= bmem[rd_a]; rd_pend <= 1'b0;
                end else rd_cnt <= rd_cnt - 1;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_store(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        st_valid = 1'b1; st_addr = a; st_data = d; st_be = be;
        while (!st_ready) @(negedge clk);
        @(negedge clk);
        st_valid = 1'b0;
    endtask

    task automatic do_read(input logic [7:0] a, input logic [31:0] exp, input string tag);
        int c;
        @(negedge clk);
        rd_req_valid = 1'b1; rd_req_addr = a;
        while (!rd_req_ready) @(negedge clk);
        @(negedge clk);
        rd_req_valid = 1'b0;
        chk(rd_req_ready == 1'b0, "R9 ready low after accept", {31'd0, rd_req_ready}, 32'd0);
        c = 0;
        while (!rd_resp_valid && c < 100) begin @(negedge clk); c++; end
        chk(rd_resp_valid && rd_resp_data == exp, tag, rd_resp_data, exp);
        @(negedge clk);
        chk(rd_resp_valid == 1'b0, "R9 response pulse", {31'd0, rd_resp_valid}, 32'd0);
    endtask

    // {op, addr, data, be, expected}; op 0 store, 1 read, 2 set wr_open=data[0] and wait, 3 check st_ready==data[0]
    localparam int NV = 17;
    localparam logic [77:0] VECS [NV] = '{
        {2'd0, 8'h02, 32'hAAAA0001, 4'hF, 32'h0},         // R2 store
        {2'd1, 8'h03, 32'h0,        4'h0, 32'h33333333},  // R6 R5 no match
        {2'd0, 8'h05, 32'h0000BB00, 4'h2, 32'h0},
        {2'd0, 8'h05, 32'hCC000000, 4'h8, 32'h0},
        {2'd0, 8'h05, 32'h0000DD00, 4'h2, 32'h0},
        {2'd1, 8'h05, 32'h0,        4'h0, 32'hCC55DD55},  // R7 youngest wins
        {2'd3, 8'h00, 32'h0,        4'h0, 32'h0},         // R2 full
        {2'd1, 8'h02, 32'h0,        4'h0, 32'hAAAA0001},  // R8 full cover
        {2'd2, 8'h00, 32'h1,        4'h0, 32'h0},
        {2'd3, 8'h00, 32'h1,        4'h0, 32'h0},         // R2 ready again
        {2'd1, 8'h05, 32'h0,        4'h0, 32'hCC55DD55},  // R4 drained in order
        {2'd1, 8'h02, 32'h0,        4'h0, 32'hAAAA0001},  // R4
        {2'd2, 8'h00, 32'h0,        4'h0, 32'h0},
        {2'd0, 8'h07, 32'h12345678, 4'h1, 32'h0},
        {2'd1, 8'h07, 32'h0,        4'h0, 32'h77777778},  // R7 single byte
        {2'd2, 8'h00, 32'h1,        4'h0, 32'h0},
        {2'd1, 8'h07, 32'h0,        4'h0, 32'h77777778}   // R4 byte enable
    };

    initial begin
        repeat (4) @(negedge clk);
        chk(st_ready && rd_req_ready, "R1 ready in reset", {30'd0, st_ready, rd_req_ready}, 32'd3);
        chk(!mem_valid && !rd_resp_valid, "R1 idle in reset", {30'd0, mem_valid, rd_resp_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(st_ready && rd_req_ready, "R1 ready after reset", {30'd0, st_ready, rd_req_ready}, 32'd3);
        chk(!mem_valid && !rd_resp_valid, "R1 idle after reset", {30'd0, mem_valid, rd_resp_valid}, 32'd0);

        for (int v = 0; v < NV; v++) begin
            logic [1:0]  op;
            logic [7:0]  a;
            logic [31:0] d, e;
            logic [3:0]  be;
            {op, a, d, be, e} = VECS[v];
            case (op)
                2'd0: do_store(a, d, be);
                2'd1: do_read(a, e, $sformatf("R6 R7 R8 table row %0d read", v));
                2'd2: begin
                    @(negedge clk); wr_open = d[0];
                    repeat (20) @(negedge clk);
                end
                default: begin
                    @(negedge clk);
                    chk(st_ready == d[0], $sformatf("R2 st_ready row %0d", v), {31'd0, st_ready}, {31'd0, d[0]});
                end
            endcase
        end

        chk(first_we == 1'b0 && first_addr == 8'h03, "R5 read overtakes queued write",
            {23'd0, first_we, first_addr}, 32'h03);
        chk(nrd == 6, "R8 covered read skips memory", nrd, 32'd6);
        chk(wlog[0] == 8'h02 && wlog[1] == 8'h05 && wlog[2] == 8'h05 && wlog[3] == 8'h05,
            "R4 retire order", {wlog[0], wlog[1], wlog[2], wlog[3]}, 32'h02050505);

        // R3: store accepted while a write retires
        @(negedge clk); wr_open = 1'b0;
        do_store(8'h08, 32'h80808080, 4'hF);
        do_store(8'h09, 32'h90909090, 4'hF);
        do_store(8'h0A, 32'hA0A0A0A0, 4'hF);
        @(negedge clk);
        wr_open = 1'b1; st_valid = 1'b1; st_addr = 8'h0B; st_data = 32'hB0B0B0B0; st_be = 4'hF;
        @(negedge clk);
        wr_open = 1'b0; st_valid = 1'b0;
        chk(st_ready == 1'b1, "R3 push with pop keeps count", {31'd0, st_ready}, 32'd1);
        do_store(8'h0C, 32'hC0C0C0C0, 4'hF);
        chk(st_ready == 1'b0, "R2 full after fourth entry", {31'd0, st_ready}, 32'd0);
        repeat (3) @(negedge clk);
        chk(st_ready == 1'b0, "R2 stays full while blocked", {31'd0, st_ready}, 32'd0);
        wr_open = 1'b1;
        repeat (20) @(negedge clk);
        chk(nwr == 10, "R4 write count", nwr, 32'd10);
        chk(wlog[5] == 8'h08 && wlog[6] == 8'h09 && wlog[7] == 8'h0A && wlog[8] == 8'h0B && wlog[9] == 8'h0C,
            "R4 retire order after R3", {wlog[6], wlog[7], wlog[8], wlog[9]}, 32'h090A0B0C);
        chk(bmem[11] == 32'hB0B0B0B0, "R3 entry kept", bmem[11], 32'hB0B0B0B0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL R9 watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule